// File: doc/BRIEF.md
# USB Clock Enable Sequencer

This block sequences bring-up and shutdown of the 48 MHz clock and the reset of a full-speed USB function block. Firmware sets two request bits: one that asks for the PLL and one that enables the USB controller. The block watches three status lines from other clock domains: crystal selected as source, crystal stable, and PLL locked. Each status line goes through a two-flop synchronizer before the state machine uses it.

Bring-up follows a fixed order. The crystal must be qualified before the PLL is powered. The synchronized lock flag must be seen before the clock is declared ready. Only then may the controller leave reset. A lock timeout with a programmable limit raises a sticky error flag, which firmware clears with a one-cycle strobe.

A power manager asks to leave active mode by raising a request line. The block switches the PLL off and acknowledges only after the PLL enable has been low for a full clock. When the request drops and the PLL request bit is still set, the block re-qualifies the crystal and relocks on its own.

Top module: `usb_clk_seq`

## Requirements
- R1: After synchronous reset, `pll_en_o`, `clk_ready_o`, `sleep_ack_o` and `lock_err_o` are 0 and `usb_rst_o` is 1.
- R2: `pll_en_o` rises only while `pll_req_i` is 1 and both crystal status lines, as synchronized, are 1. Until then the request stays pending with `pll_en_o` at 0.
- R3: `clk_ready_o` is 1 only while the PLL is enabled and was seen locked. It rises one clock after the synchronized lock flag is seen while the PLL is enabled.
- R4: `usb_rst_o` is 0 only while `usb_en_i` is 1 and `clk_ready_o` is 1. Otherwise the controller is held in reset.
- R5: If the synchronized lock flag drops while ready, the block returns to waiting for lock on the next clock. `clk_ready_o` goes to 0 and `usb_rst_o` goes to 1, while `pll_en_o` stays at 1.
- R6: While `sleep_req_i` is 1, `pll_en_o` is 0 from the next clock on, whatever the state. `sleep_ack_o` rises one clock after the PLL enable went low and stays at 1 while the request is held.
- R7: On the first clock after `sleep_req_i` falls, the block goes to crystal qualification if `pll_req_i` is 1, and to off if it is 0. No rewrite of the request bit is needed.
- R8: If lock is not seen within `lock_limit_i`+1 clocks of entering the lock wait, `lock_err_o` is set. It stays set until a clock with `err_clr_i` at 1, and it is set at most once per lock wait.
- R9: Clearing `pll_req_i` takes the block to off on the next clock, so `pll_en_o` and `clk_ready_o` both go to 0.
- R10: Each status input reaches the state machine through two flops. A change on a status input alters the outputs no sooner than the third rising clock edge after it.
- R11: Loss of crystal qualification while waiting for lock or while ready returns the block to crystal qualification with `pll_en_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_en_i | input | 1 | Controller enable request bit |
| pll_req_i | input | 1 | PLL enable request bit |
| xosc_sel_i | input | 1 | Crystal selected as clock source (asynchronous) |
| xosc_stable_i | input | 1 | Crystal reports stable (asynchronous) |
| pll_locked_i | input | 1 | PLL lock indication (asynchronous) |
| sleep_req_i | input | 1 | Power manager request to leave active mode |
| lock_limit_i | input | CNT_W | Lock timeout limit in clocks |
| err_clr_i | input | 1 | One-cycle strobe that clears the lock error |
| pll_en_o | output | 1 | PLL power enable |
| usb_rst_o | output | 1 | USB controller reset, active high |
| clk_ready_o | output | 1 | USB clock usable |
| sleep_ack_o | output | 1 | Leave-active acknowledge |
| lock_err_o | output | 1 | Sticky lock timeout error |

## Verification
The hardest cases are the ones where events overlap: lock lost while ready, crystal lost during the lock wait, and a timeout that runs out just as firmware clears the flag. Each of these depends on the exact three-edge latency of the synchronizers.

The stimulus reaches each case by holding one status line steady and toggling another on a falling edge. It then samples the outputs at the second and third rising edges after that, to pin down where each transition lands. Sleep entries are issued from the ready state, from crystal qualification, and with the request bit cleared during sleep, so that both wake paths are exercised.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_WAIT_XOSC = 3'd1,
        ST_WAIT_LOCK = 3'd2,
        ST_READY     = 3'd3,
        ST_SUSP      = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic xosc_sel;
        logic xosc_stable;
        logic pll_locked;
    } clk_status_t;

    localparam int STATUS_W    = $bits(clk_status_t);
    localparam int SYNC_STAGES = 2;

    function automatic logic xosc_ok(clk_status_t s);
        return s.xosc_sel & s.xosc_stable;
    endfunction

    function automatic logic pll_powered(seq_state_e s);
        return (s == ST_WAIT_LOCK) || (s == ST_READY);
    endfunction

endpackage

// File: rtl/usbclk_sync.sv
module usbclk_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    // R10: a rising synchronized bit was high at the input two edges before
    generate
        if (STAGES == 2) begin : g_chk
            for (genvar b = 0; b < W; b++) begin : g_bit
                p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
                    $rose(q[b]) |-> $past(d[b], 2));
            end
        end
    endgenerate
endmodule

// File: rtl/usbclk_lock_timer.sv
module usbclk_lock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr,
    output logic             err_o
);
    logic [CNT_W-1:0] cnt;
    logic             fired;
    logic             err_q;
    logic             hit;

    assign hit = armed && (cnt == limit) && !fired;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            fired <= 1'b0;
            err_q <= 1'b0;
        end else begin
            err_q <= hit | (err_q & ~clr);
            if (!armed) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else begin
                if (cnt != limit) cnt <= cnt + 1'b1;
                if (hit) fired <= 1'b1;
            end
        end
    end

    assign err_o = err_q;

    // R8: flag is sticky until cleared
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr) |=> err_q);
    // R8: flag only rises out of a lock wait
    p_err_from_wait_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(armed));
endmodule

// File: rtl/usbclk_fsm.sv
module usbclk_fsm
    import usbclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  clk_status_t status,
    input  logic        pll_req_i,
    input  logic        sleep_req_i,
    output seq_state_e  state_o,
    output logic        pll_en_o,
    output logic        ready_o,
    output logic        ack_o
);
    seq_state_e st, nxt;
    logic       ack_q;
    logic       xok;
    logic       lk;

    assign xok = xosc_ok(status);
    assign lk  = status.pll_locked;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (sleep_req_i)    nxt = ST_SUSP;
                else if (pll_req_i) nxt = ST_WAIT_XOSC;
            end
            ST_WAIT_XOSC: begin
                if (sleep_req_i)     nxt = ST_SUSP;
                else if (!pll_req_i) nxt = ST_OFF;
                else if (xok)        nxt = ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (sleep_req_i)     nxt = ST_SUSP;
                else if (!pll_req_i) nxt = ST_OFF;
                else if (!xok)       nxt = ST_WAIT_XOSC;
                else if (lk)         nxt = ST_READY;
            end
            ST_READY: begin
                if (sleep_req_i)     nxt = ST_SUSP;
                else if (!pll_req_i) nxt = ST_OFF;
                else if (!xok)       nxt = ST_WAIT_XOSC;
                else if (!lk)        nxt = ST_WAIT_LOCK;
            end
            ST_SUSP: begin
                if (!sleep_req_i) nxt = pll_req_i ? ST_WAIT_XOSC : ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_OFF;
            ack_q <= 1'b0;
        end else begin
            st    <= nxt;
            ack_q <= (st == ST_SUSP) && sleep_req_i;
        end
    end

    assign state_o  = st;
    assign pll_en_o = pll_powered(st);
    assign ready_o  = (st == ST_READY);
    assign ack_o    = ack_q;

    // R2: PLL only powers up after crystal qualification
    p_pll_after_xosc_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en_o) |-> $past(xok));
    // R3: ready only follows a seen lock with PLL on
    p_ready_after_lock_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(lk) && pll_en_o));
    // R6: leave-active request forces the PLL off
    p_sleep_pll_off_r6: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_req_i) |-> !pll_en_o);
    // R6: acknowledge only after a full clock with PLL off
    p_ack_gap_r6: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (!pll_en_o && $past(!pll_en_o)));
    // R7: wake with request set re-enters crystal qualification
    p_wake_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && !sleep_req_i && pll_req_i) |=> (st == ST_WAIT_XOSC));
endmodule

// File: rtl/usb_clk_seq.sv
module usb_clk_seq
    import usbclk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             usb_en_i,
    input  logic             pll_req_i,
    input  logic             xosc_sel_i,
    input  logic             xosc_stable_i,
    input  logic             pll_locked_i,
    input  logic             sleep_req_i,
    input  logic [CNT_W-1:0] lock_limit_i,
    input  logic             err_clr_i,
    output logic             pll_en_o,
    output logic             usb_rst_o,
    output logic             clk_ready_o,
    output logic             sleep_ack_o,
    output logic             lock_err_o
);
    clk_status_t raw_status;
    clk_status_t sync_status;
    seq_state_e  state;
    logic        pll_on;
    logic        ready;

    always_comb begin
        raw_status.xosc_sel    = xosc_sel_i;
        raw_status.xosc_stable = xosc_stable_i;
        raw_status.pll_locked  = pll_locked_i;
    end

    usbclk_sync #(.W(STATUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_status),
        .q   (sync_status)
    );

    usbclk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .status      (sync_status),
        .pll_req_i   (pll_req_i),
        .sleep_req_i (sleep_req_i),
        .state_o     (state),
        .pll_en_o    (pll_on),
        .ready_o     (ready),
        .ack_o       (sleep_ack_o)
    );

    usbclk_lock_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .armed (state == ST_WAIT_LOCK),
        .limit (lock_limit_i),
        .clr   (err_clr_i),
        .err_o (lock_err_o)
    );

    assign pll_en_o    = pll_on;
    assign clk_ready_o = ready;
    assign usb_rst_o   = !(usb_en_i && ready);

    // R4: controller leaves reset only with the PLL running and enable set
    p_rst_release_r4: assert property (@(posedge clk) disable iff (rst)
        !usb_rst_o |-> (pll_en_o && usb_en_i));
    // R1: reset values seen on the first clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pll_en_o && !clk_ready_o && usb_rst_o && !sleep_ack_o));
endmodule

// File: tb/usb_clk_seq_test.sv
module usb_clk_seq_test;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic usb_en = 0, pll_req = 0, x_sel = 0, x_stb = 0, locked = 0;
    logic sleep = 0, clr = 0;
    logic [CW-1:0] limit = 16'd40;
    logic pll_en, usb_rst, rdy, ack, err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    usb_clk_seq #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .usb_en_i(usb_en), .pll_req_i(pll_req),
        .xosc_sel_i(x_sel), .xosc_stable_i(x_stb), .pll_locked_i(locked),
        .sleep_req_i(sleep), .lock_limit_i(limit), .err_clr_i(clr),
        .pll_en_o(pll_en), .usb_rst_o(usb_rst), .clk_ready_o(rdy),
        .sleep_ack_o(ack), .lock_err_o(err)
    );

    always #10 clk = ~clk;

    // reference model
    localparam int M_OFF = 0, M_WX = 1, M_WL = 2, M_RDY = 3, M_SL = 4;
    int m_st = M_OFF;
    int m_cnt = 0;
    bit m_fired = 0, m_err = 0, m_ack = 0;
    bit [2:0] m_p1 = 0, m_p2 = 0; // [2] sel, [1] stable, [0] lock

    always @(posedge clk) begin
        if (rst) begin
            m_st = M_OFF; m_cnt = 0; m_fired = 0; m_err = 0; m_ack = 0;
            m_p1 = 0; m_p2 = 0;
        end else begin
            bit xok, lk, hit;
            int nst;
            xok = m_p2[2] && m_p2[1];
            lk  = m_p2[0];
            m_ack = (m_st == M_SL) && sleep;
            hit = (m_st == M_WL) && (m_cnt == int'(limit)) && !m_fired;
            m_err = hit || (m_err && !clr);
            if (m_st != M_WL) begin
                m_cnt = 0; m_fired = 0;
            end else begin
                if (m_cnt != int'(limit)) m_cnt++;
                if (hit) m_fired = 1;
            end
            nst = m_st;
            if (m_st == M_SL) nst = sleep ? M_SL : (pll_req ? M_WX : M_OFF);
            else if (sleep) nst = M_SL;
            else if (m_st == M_OFF) nst = pll_req ? M_WX : M_OFF;
            else if (!pll_req) nst = M_OFF;
            else if (!xok) nst = M_WX;
            else if (m_st == M_WX) nst = M_WL;
            else if (m_st == M_WL) nst = lk ? M_RDY : M_WL;
            else nst = lk ? M_RDY : M_WL;
            m_st = nst;
            m_p2 = m_p1;
            m_p1 = {x_sel, x_stb, locked};
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            bit e_pll, e_rdy;
            e_pll = (m_st == M_WL) || (m_st == M_RDY);
            e_rdy = (m_st == M_RDY);
            chk("R2 R10 R11 model pll_en", pll_en, e_pll);
            chk("R3 R5 model ready", rdy, e_rdy);
            chk("R4 model usb_rst", usb_rst, !(usb_en && e_rdy));
            chk("R6 model ack", ack, m_ack);
            chk("R8 model err", err, m_err);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        chk("R1 pll_en after reset", pll_en, 0);
        chk("R1 ready after reset", rdy, 0);
        chk("R1 usb_rst after reset", usb_rst, 1);
        chk("R1 ack after reset", ack, 0);
        chk("R1 err after reset", err, 0);

        // R2: pending until crystal qualified
        pll_req = 1; x_stb = 1;
        cyc(10);
        chk("R2 pending without crystal select", pll_en, 0);
        x_sel = 1;
        cyc(2);
        chk("R10 pll still off two edges after crystal ok", pll_en, 0);
        cyc(1);
        chk("R2 pll on after crystal ok", pll_en, 1);

        // R3 / R4
        locked = 1;
        cyc(2);
        chk("R10 ready still low two edges after lock", rdy, 0);
        cyc(1);
        chk("R3 ready after lock", rdy, 1);
        chk("R4 reset held while usb_en low", usb_rst, 1);
        usb_en = 1;
        cyc(1);
        chk("R4 reset released", usb_rst, 0);

        // R5 lock loss
        locked = 0;
        cyc(3);
        chk("R5 ready low on lock loss", rdy, 0);
        chk("R5 reset reasserted", usb_rst, 1);
        chk("R5 pll stays on", pll_en, 1);
        locked = 1;
        cyc(3);
        chk("R5 ready back", rdy, 1);

        // R11 crystal loss
        x_stb = 0;
        cyc(3);
        chk("R11 pll off on crystal loss", pll_en, 0);
        chk("R11 ready off on crystal loss", rdy, 0);
        x_stb = 1;
        cyc(3);
        chk("R11 pll back on", pll_en, 1);
        cyc(1);
        chk("R11 ready back", rdy, 1);

        // R6 sleep from ready
        sleep = 1;
        cyc(1);
        chk("R6 pll off after sleep request", pll_en, 0);
        chk("R6 no ack yet", ack, 0);
        cyc(1);
        chk("R6 ack after gap", ack, 1);
        cyc(5);
        chk("R6 ack held", ack, 1);
        chk("R6 pll held off", pll_en, 0);

        // R7 wake with request set
        sleep = 0;
        cyc(1);
        chk("R7 ack drops on wake", ack, 0);
        chk("R7 pll off while qualifying", pll_en, 0);
        cyc(1);
        chk("R7 pll on without rewrite", pll_en, 1);
        cyc(1);
        chk("R7 ready after wake", rdy, 1);

        // R7 wake with request cleared
        sleep = 1;
        cyc(2);
        pll_req = 0;
        cyc(3);
        sleep = 0;
        cyc(3);
        chk("R7 off after wake without request", pll_en, 0);
        pll_req = 1;
        cyc(2);
        chk("R7 pll on after fresh request", pll_en, 1);
        cyc(1);
        chk("R7 ready after fresh request", rdy, 1);

        // R9 request cleared
        pll_req = 0;
        cyc(1);
        chk("R9 pll off on request clear", pll_en, 0);
        chk("R9 ready off on request clear", rdy, 0);
        chk("R9 reset asserted", usb_rst, 1);

        // R8 timeout with limit 10
        locked = 0; limit = 16'd10;
        cyc(3);
        pll_req = 1;
        cyc(12);
        chk("R8 no error before limit", err, 0);
        cyc(1);
        chk("R8 error at limit", err, 1);
        cyc(20);
        chk("R8 error sticky", err, 1);
        clr = 1;
        cyc(1);
        clr = 0;
        chk("R8 error cleared by strobe", err, 0);
        cyc(5);
        chk("R8 set once per wait", err, 0);
        locked = 1;
        cyc(3);
        chk("R3 ready after late lock", rdy, 1);

        // R8 limit zero
        pll_req = 0; locked = 0; limit = '0;
        cyc(4);
        pll_req = 1;
        cyc(2);
        chk("R8 zero limit not yet", err, 0);
        cyc(1);
        chk("R8 zero limit error", err, 1);
        clr = 1;
        cyc(1);
        clr = 0;
        chk("R8 cleared again", err, 0);

        // R6 sleep while qualifying crystal
        x_sel = 0;
        cyc(4);
        chk("R2 held pending again", pll_en, 0);
        sleep = 1;
        cyc(2);
        chk("R6 ack from qualification", ack, 1);
        sleep = 0;
        cyc(4);
        finish_run();
    end
endmodule